// File: doc/BRIEF.md
# Two-Sided Message Mailbox

This block passes 32-bit messages between a compute engine and a host. The compute engine talks to it through a channel port that uses request/acknowledge handshakes. The host talks to it through a simple memory-mapped register port. Host-to-compute traffic goes through a four-entry inbound queue. Compute-to-host traffic goes through a single-entry outbound slot.

The two sides behave differently when the mailbox is empty or full:

- **Compute side.** It waits. A read request against an empty inbound queue, or a write request against a full outbound slot, is held unacknowledged until the other side makes progress. The compute side can also read the inbound message count and the free outbound slot count directly.
- **Host side.** It never waits. Reading an empty outbound slot yields zero. Writing a full inbound queue replaces the newest queued message. A packed status word reports both occupancies.

Top module: `mbox_unit`

## Requirements
- R1: Messages are 32 bits wide. The inbound queue holds up to 4 messages, which are delivered to the compute side oldest first. The outbound slot holds 1 message.
- R2: While `c_rd_req` is high and the inbound queue is not empty, `c_rd_ack` is high in the same cycle. `c_rd_data` then carries the oldest message, and that message is removed at the clock edge. While the queue is empty, `c_rd_ack` stays low (a stall).
- R3: While `c_wr_req` is high and the outbound slot is free, `c_wr_ack` is high in the same cycle and `c_wr_data` is stored at the edge. While the slot is occupied, `c_wr_ack` stays low.
- R4: `c_in_count` reports the number of queued inbound messages and `c_out_free` reports the number of free outbound slots. Both change in the cycle after the push or pop that affects them.
- R5: Host register offsets on `h_addr` are as follows. Offset 0 is inbound data (write). Offset 1 is outbound data (read). Offset 2 is status (read). `h_rd_data` is valid in the same cycle as `h_rd_en`.
- R6: A host read of offset 1 while the outbound slot is empty returns 0 and changes no state.
- R7: A host write to offset 0 while the inbound queue holds 4 messages replaces the newest message and leaves the count at 4. If the compute side pops in the same cycle, the write is queued normally instead.
- R8: The status word carries the outbound message count in bits 7:0 and the free inbound slot count in bits 15:8. Bits 31:16 are zero.
- R9: A host read of offset 1 while the slot is full returns the message and empties the slot. A compute write stalled on that slot is acknowledged in the next cycle.
- R10: After a synchronous active-low reset, both mailboxes are empty: `c_in_count` is 0, `c_out_free` is 1 and the status word reads 0x00000400.
- R11: Host writes to offsets 1, 2 and 3 have no effect. Host reads of offsets 0 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| c_rd_req | input | 1 | Compute read request |
| c_rd_ack | output | 1 | Compute read acknowledge |
| c_rd_data | output | 32 | Oldest inbound message |
| c_wr_req | input | 1 | Compute write request |
| c_wr_data | input | 32 | Outbound message to store |
| c_wr_ack | output | 1 | Compute write acknowledge |
| c_in_count | output | 3 | Queued inbound messages |
| c_out_free | output | 1 | Free outbound slots |
| h_wr_en | input | 1 | Host register write strobe |
| h_rd_en | input | 1 | Host register read strobe |
| h_addr | input | 2 | Host register offset |
| h_wr_data | input | 32 | Host write data |
| h_rd_data | output | 32 | Host read data |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Overwrite of a full inbound queue.** A design that drops the message instead, or overwrites the oldest entry, delivers the wrong fourth message.
- **Host write during a compute pop on a full queue.** A design that overwrites here loses a message.
- **Host read of an empty outbound slot.** A design that does not return zero shows stale data.
- **Release of a stalled compute write.** The release must come exactly one cycle after the host pops the slot. An early or late acknowledge, or a second store over an unread message, is caught.
- **Count timing and reserved regions.** Count and status checks fall in the cycle after each push or pop, which catches counts that update too early or too late. Writes to reserved offsets that corrupt state are also caught.

// File: rtl/mbox_pkg.sv
// Shared constants for the mailbox unit: host register offsets and status field width.
package mbox_pkg;
    typedef enum logic [1:0] {
        HA_IN_DATA  = 2'd0,
        HA_OUT_DATA = 2'd1,
        HA_STATUS   = 2'd2,
        HA_RSVD     = 2'd3
    } host_addr_e;

    localparam int STAT_FIELD_W = 8;
endpackage

// File: rtl/mbox_fifo.sv
// Small circular message queue with a registered occupancy count.
// Assumes pop is only asserted while the queue is not empty.
// OVERWRITE=1 makes a push into a full queue (with no pop in the same cycle)
// replace the newest entry; OVERWRITE=0 drops such a push (the caller gates it).
module mbox_fifo #(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 4,
    parameter bit OVERWRITE = 1'b0,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST   = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, newest;
    logic              full, do_push, do_ovw;

    assign full    = (count == FULL_C);
    assign do_push = push && (!full || pop);
    assign newest  = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
    assign head    = mem[rd_ptr];

    // Select whether a push into a full queue replaces the newest entry.
    generate
        if (OVERWRITE) begin : g_ovw
            assign do_ovw = push && full && !pop;
        end else begin : g_drop
            assign do_ovw = 1'b0;
        end
    endgenerate

    // Advance a pointer around the ring.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Storage and pointer update for push, overwrite and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= bump(wr_ptr);
            end else if (do_ovw) begin
                mem[newest] <= push_data;
            end
            if (pop) rd_ptr <= bump(rd_ptr);
        end
    end

    // Occupancy count, visible one cycle after each push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (do_push && !pop)  count <= count + 1'b1;
        else if (!do_push && pop)  count <= count - 1'b1;
    end
endmodule

// File: rtl/mbox_host_if.sv
// Host register decode: routes writes to the inbound queue, pops the outbound
// slot on data reads, and builds the packed status word. Never stalls; reads
// are combinational in the strobe cycle.
module mbox_host_if
    import mbox_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 1,
    localparam int IN_CW    = $clog2(IN_DEPTH + 1),
    localparam int OUT_CW   = $clog2(OUT_DEPTH + 1)
) (
    input  logic              h_wr_en,
    input  logic              h_rd_en,
    input  logic [1:0]        h_addr,
    input  logic [DATA_W-1:0] h_wr_data,
    input  logic [DATA_W-1:0] out_head,
    input  logic [OUT_CW-1:0] out_count,
    input  logic [IN_CW-1:0]  in_count,
    output logic              in_push,
    output logic [DATA_W-1:0] in_push_data,
    output logic              out_pop,
    output logic [DATA_W-1:0] h_rd_data
);
    logic [IN_CW-1:0] in_free;
    logic             out_has;

    assign in_free      = IN_CW'(IN_DEPTH) - in_count;
    assign out_has      = (out_count != '0);
    assign in_push      = h_wr_en && (h_addr == HA_IN_DATA);
    assign in_push_data = h_wr_data;
    assign out_pop      = h_rd_en && (h_addr == HA_OUT_DATA) && out_has;

    // Read data mux: outbound message, status word, or zero.
    always_comb begin
        h_rd_data = '0;
        if (h_rd_en) begin
            case (h_addr)
                HA_OUT_DATA: if (out_has) h_rd_data = out_head;
                HA_STATUS:   h_rd_data = DATA_W'({STAT_FIELD_W'(in_free),
                                                  STAT_FIELD_W'(out_count)});
                default:     h_rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbox_unit.sv
// Two-sided mailbox: 4-deep inbound queue (host to compute) and 1-deep
// outbound slot (compute to host). The compute side handshakes and stalls;
// the host side never blocks. Synchronous active-low reset.
module mbox_unit #(
    parameter int DATA_W    = 32,
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              c_rd_req,
    output logic                              c_rd_ack,
    output logic [DATA_W-1:0]                 c_rd_data,
    input  logic                              c_wr_req,
    input  logic [DATA_W-1:0]                 c_wr_data,
    output logic                              c_wr_ack,
    output logic [$clog2(IN_DEPTH+1)-1:0]     c_in_count,
    output logic [$clog2(OUT_DEPTH+1)-1:0]    c_out_free,
    input  logic                              h_wr_en,
    input  logic                              h_rd_en,
    input  logic [1:0]                        h_addr,
    input  logic [DATA_W-1:0]                 h_wr_data,
    output logic [DATA_W-1:0]                 h_rd_data
);
    localparam int IN_CW  = $clog2(IN_DEPTH + 1);
    localparam int OUT_CW = $clog2(OUT_DEPTH + 1);

    logic              in_push, out_pop;
    logic [DATA_W-1:0] in_push_data, out_head;
    logic [IN_CW-1:0]  in_count;
    logic [OUT_CW-1:0] out_count;

    assign c_rd_ack   = c_rd_req && (in_count != '0);
    assign c_wr_ack   = c_wr_req && (out_count != OUT_CW'(OUT_DEPTH));
    assign c_in_count = in_count;
    assign c_out_free = OUT_CW'(OUT_DEPTH) - out_count;

    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(IN_DEPTH), .OVERWRITE(1'b1)) i_in_q (
        .clk(clk), .rst_n(rst_n),
        .push(in_push), .push_data(in_push_data),
        .pop(c_rd_ack), .head(c_rd_data), .count(in_count)
    );

    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(OUT_DEPTH), .OVERWRITE(1'b0)) i_out_q (
        .clk(clk), .rst_n(rst_n),
        .push(c_wr_ack), .push_data(c_wr_data),
        .pop(out_pop), .head(out_head), .count(out_count)
    );

    mbox_host_if #(.DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) i_host (
        .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr), .h_wr_data(h_wr_data),
        .out_head(out_head), .out_count(out_count), .in_count(in_count),
        .in_push(in_push), .in_push_data(in_push_data),
        .out_pop(out_pop), .h_rd_data(h_rd_data)
    );
endmodule

// File: rtl/mbox_unit_chk.sv
// Protocol checker for mbox_unit, observing only its ports; bound below.
module mbox_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           c_rd_req,
    input logic                           c_rd_ack,
    input logic [DATA_W-1:0]              c_rd_data,
    input logic                           c_wr_req,
    input logic [DATA_W-1:0]              c_wr_data,
    input logic                           c_wr_ack,
    input logic [$clog2(IN_DEPTH+1)-1:0]  c_in_count,
    input logic [$clog2(OUT_DEPTH+1)-1:0] c_out_free,
    input logic                           h_wr_en,
    input logic                           h_rd_en,
    input logic [1:0]                     h_addr,
    input logic [DATA_W-1:0]              h_wr_data,
    input logic [DATA_W-1:0]              h_rd_data
);
    logic h_push, h_pop;
    assign h_push = h_wr_en && (h_addr == 2'd0);
    assign h_pop  = h_rd_en && (h_addr == 2'd1) && (c_out_free == '0);

    // R1: the inbound count never exceeds the queue depth.
    p_in_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        c_in_count <= ($clog2(IN_DEPTH+1))'(IN_DEPTH));

    // R2: no read acknowledge while the inbound queue is empty.
    p_rd_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_in_count == '0) |-> !c_rd_ack);

    // R3: no write acknowledge while the outbound slot is occupied.
    p_wr_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_out_free == '0) |-> !c_wr_ack);

    // R4: a lone compute pop lowers the count by one in the next cycle.
    p_pop_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd_ack && !h_push) |=> (c_in_count == $past(c_in_count) - 1'b1));

    // R6: an empty outbound read returns zero.
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_en && h_addr == 2'd1 && c_out_free != '0) |-> (h_rd_data == '0));

    // R7: an overwrite of a full queue keeps it full.
    p_ovw_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_push && !c_rd_ack && c_in_count == ($clog2(IN_DEPTH+1))'(IN_DEPTH))
        |=> (c_in_count == ($clog2(IN_DEPTH+1))'(IN_DEPTH)));

    // R8: upper status bits are zero.
    p_stat_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_en && h_addr == 2'd2) |-> (h_rd_data[DATA_W-1:16] == '0));

    // R9: a write stalled on the slot is released right after the host pop.
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr_req && h_pop) |=> (c_wr_ack || !c_wr_req));
endmodule

bind mbox_unit mbox_unit_chk #(.DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .c_rd_req(c_rd_req), .c_rd_ack(c_rd_ack), .c_rd_data(c_rd_data),
    .c_wr_req(c_wr_req), .c_wr_data(c_wr_data), .c_wr_ack(c_wr_ack), .c_in_count(c_in_count),
    .c_out_free(c_out_free), .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr),
    .h_wr_data(h_wr_data), .h_rd_data(h_rd_data)
);

// File: tb/test_mbox_unit.sv
// Self-checking bench: host-side vector table, then directed compute-side tests.
module test_mbox_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_rd_req = 1'b0, c_wr_req = 1'b0;
    logic [31:0] c_wr_data = '0;
    logic        h_wr_en = 1'b0, h_rd_en = 1'b0;
    logic [1:0]  h_addr = '0;
    logic [31:0] h_wr_data = '0;
    logic        c_rd_ack, c_wr_ack;
    logic [31:0] c_rd_data, h_rd_data;
    logic [2:0]  c_in_count;
    logic [0:0]  c_out_free;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mbox_unit i_mbox_unit (
        .clk(clk), .rst_n(rst_n),
        .c_rd_req(c_rd_req), .c_rd_ack(c_rd_ack), .c_rd_data(c_rd_data),
        .c_wr_req(c_wr_req), .c_wr_data(c_wr_data), .c_wr_ack(c_wr_ack),
        .c_in_count(c_in_count), .c_out_free(c_out_free),
        .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr),
        .h_wr_data(h_wr_data), .h_rd_data(h_rd_data)
    );

    // Vector: {wr, rd, addr[1:0], wdata[31:0], expected read[31:0]}
    localparam int NV = 14;
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd2, 32'h0,    32'h0000_0400},
        {1'b0, 1'b1, 2'd1, 32'h0,    32'h0},
        {1'b1, 1'b0, 2'd0, 32'h11,   32'h0},
        {1'b0, 1'b1, 2'd2, 32'h0,    32'h0000_0300},
        {1'b1, 1'b0, 2'd3, 32'hDEAD, 32'h0},
        {1'b1, 1'b0, 2'd2, 32'hBEEF, 32'h0},
        {1'b0, 1'b1, 2'd2, 32'h0,    32'h0000_0300},
        {1'b0, 1'b1, 2'd0, 32'h0,    32'h0},
        {1'b1, 1'b0, 2'd0, 32'h22,   32'h0},
        {1'b1, 1'b0, 2'd0, 32'h33,   32'h0},
        {1'b1, 1'b0, 2'd0, 32'h44,   32'h0},
        {1'b0, 1'b1, 2'd2, 32'h0,    32'h0},
        {1'b1, 1'b0, 2'd0, 32'h55,   32'h0},
        {1'b0, 1'b1, 2'd2, 32'h0,    32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        c_rd_req = 1'b0; c_wr_req = 1'b0; h_wr_en = 1'b0; h_rd_en = 1'b0; h_addr = '0;
    endtask

    task automatic host(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        idle();
        h_wr_en = wr; h_rd_en = rd; h_addr = a; h_wr_data = d;
        #1;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R10 in count", 32'(c_in_count), 32'd0);
        chk("R10 out free", 32'(c_out_free), 32'd1);

        // Host-side vector walk (R5 R6 R7 R8 R11)
        for (int v = 0; v < NV; v++) begin
            host(VEC[v][67], VEC[v][66], VEC[v][65:64], VEC[v][63:32]);
            if (VEC[v][66]) chk($sformatf("R5/R8/R11 vector %0d", v), h_rd_data, VEC[v][31:0]);
        end

        // Compute drain: oldest first, 0x44 replaced by 0x55 (R1 R7 R2 R4)
        begin
            logic [31:0] exp_q [4] = '{32'h11, 32'h22, 32'h33, 32'h55};
            for (int i = 0; i < 4; i++) begin
                @(negedge clk); idle(); c_rd_req = 1'b1; #1;
                chk("R4 in count before pop", 32'(c_in_count), 32'(4 - i));
                chk("R2 read ack", 32'(c_rd_ack), 32'd1);
                chk("R1 R7 read data", c_rd_data, exp_q[i]);
            end
        end
        @(negedge clk); #1;
        chk("R2 empty stall", 32'(c_rd_ack), 32'd0);
        h_wr_en = 1'b1; h_addr = 2'd0; h_wr_data = 32'h66;
        @(negedge clk); h_wr_en = 1'b0; #1;
        chk("R4 count after push", 32'(c_in_count), 32'd1);
        chk("R2 stalled read released", 32'(c_rd_ack), 32'd1);
        chk("R2 released data", c_rd_data, 32'h66);
        @(negedge clk); idle(); #1;

        // Full queue with simultaneous pop and host write (R7)
        for (int i = 1; i <= 4; i++) host(1'b1, 1'b0, 2'd0, 32'(i));
        @(negedge clk); idle(); c_rd_req = 1'b1; h_wr_en = 1'b1; h_addr = 2'd0; h_wr_data = 32'h5; #1;
        chk("R7 pop during full write", c_rd_data, 32'h1);
        for (int i = 2; i <= 5; i++) begin
            @(negedge clk); idle(); c_rd_req = 1'b1; #1;
            chk("R7 queued not overwritten", c_rd_data, 32'(i));
        end

        // Compute writes and host reads of the outbound slot (R3 R9 R6 R8)
        @(negedge clk); idle(); c_wr_req = 1'b1; c_wr_data = 32'hA1; #1;
        chk("R3 write ack free slot", 32'(c_wr_ack), 32'd1);
        @(negedge clk); c_wr_data = 32'hA2; h_rd_en = 1'b1; h_addr = 2'd2; #1;
        chk("R3 write stall full", 32'(c_wr_ack), 32'd0);
        chk("R4 out free after push", 32'(c_out_free), 32'd0);
        chk("R8 status full outbound", h_rd_data, 32'h0000_0401);
        @(negedge clk); h_addr = 2'd1; #1;
        chk("R9 host read data", h_rd_data, 32'hA1);
        chk("R3 still stalled", 32'(c_wr_ack), 32'd0);
        @(negedge clk); h_rd_en = 1'b0; #1;
        chk("R9 stalled write released", 32'(c_wr_ack), 32'd1);
        host(1'b0, 1'b1, 2'd1, 32'h0);
        chk("R9 second message", h_rd_data, 32'hA2);
        host(1'b0, 1'b1, 2'd1, 32'h0);
        chk("R6 empty read zero", h_rd_data, 32'h0);
        host(1'b0, 1'b1, 2'd2, 32'h0);
        chk("R6 status unchanged", h_rd_data, 32'h0000_0400);

        // Reset with data in both mailboxes (R10)
        host(1'b1, 1'b0, 2'd0, 32'h77);
        @(negedge clk); idle(); c_wr_req = 1'b1; c_wr_data = 32'hB1;
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R10 in count after reset", 32'(c_in_count), 32'd0);
        chk("R10 out free after reset", 32'(c_out_free), 32'd1);
        host(1'b0, 1'b1, 2'd2, 32'h0);
        chk("R10 status after reset", h_rd_data, 32'h0000_0400);
        @(negedge clk); idle();

        finished = 1'b1;
        report();
    end
endmodule